// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block is the control front end of a parallel NOR-style flash device, modelled in synthesizable form. It sits behind an asynchronous bus made of active-low chip enable, output enable and write enable strobes, an active-low reset, an address bus, and split data-in and data-out buses. Two-flop synchronisers bring the strobes into the system clock domain. The control logic then sorts each cycle into a read, a command write, or standby.

After reset the controller reads the array with no command needed. A three-word unlock sequence switches reads over to a separate identification register. Any word that is wrong or arrives out of order drops the controller back to array reads, and so does an explicit exit command. The array itself is a small read-only register file whose contents are computed.

A standby flag tells the host when the device is deselected. While that flag is set, the data outputs stay released. For a short window after the identification sequence completes, an internal operation keeps the device active. A separate timer watches the address bus and raises a low-power flag once the address has held still for a set number of clocks.

Top module: `nor_bus_front`

## Requirements
- R1: While rstN is low, and after rstN is released, the controller is in array-read mode. While rstN is low, dataOutEn=0, standby=1 and lowPower=0.
- R2: When the synchronised strobes show ceN=0, oeN=0 and weN=1, dataOutEn=1 two clocks after the strobes settle. In array mode, dataOut then equals word i = ((i*0x1357) XOR 0xC0DE) mod 2^16, where i = addr[3:0].
- R3: A command word (addr, dataIn) is taken only on a rising edge of the synchronised weN while the synchronised ceN is low and oeN is high. A write done with oeN low has no effect on the mode.
- R4: Writing 0x00AA to 0x555, then 0x0055 to 0x2AA, then 0x0090 to 0x555 enters identification mode. Both the address and the full data word must match.
- R5: In identification mode, a read returns 0x003D when addr[0]=0 and 0x00A7 when addr[0]=1. The code sits on bits 7..0 and the upper byte is zero.
- R6: Any command word that does not match the next expected unlock word returns the controller to array-read mode and restarts the sequence.
- R7: Writing 0x00F0 to any address returns the controller to array-read mode from any state.
- R8: standby=1 and dataOutEn=0 while rstN is low, or while the synchronised ceN is high and no internal operation is running, whatever the level of oeN.
- R9: If ceN is low when rstN is released, standby is 0 in the first cycle after the release, with no recovery delay.
- R10: Completing the identification sequence starts an internal operation of 8 clocks. During that operation standby stays 0 even if ceN is high.
- R11: lowPower rises once addr has been unchanged for 12 consecutive clock samples. Any change of address clears it at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| addr | input | 11 | Address bus |
| dataIn | input | 16 | Data bus from the host (command words) |
| dataOut | output | 16 | Data bus to the host |
| dataOutEn | output | 1 | Output drive enable; 0 means high impedance |
| standby | output | 1 | Device deselected or held in reset |
| lowPower | output | 1 | Address held stable long enough for automatic low power |

## Verification
The bench goes after sequences that nearly unlock. In one, the second address is off by one. In another, a junk word is written once identification mode is already set. A third repeats the full unlock with output enable held low. A sequencer that skipped the address compare, or that sampled writes without checking the strobes, would wrongly show identification codes in these cases. The bench also raises chip enable just after the last unlock word, where a design that ignored the internal operation would flag standby too early. Finally it holds the address through the low-power threshold and then changes it by one step, which exposes an off-by-one timer or one that never clears. Reset is applied in the middle of identification mode, and a design that kept its mode across reset would return identification codes afterwards.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic readEn;
    logic idMode;
    logic standby;
  } ctrlStrobes_t;

  // computed array content for word index idx
  function automatic logic [31:0] arrayWord(input int unsigned idx);
    logic [31:0] v;
    v = (idx * 32'h0000_1357) ^ 32'h0000_C0DE;
    return v;
  endfunction

endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1[b] <= RESET_VAL[b];
          stage2[b] <= RESET_VAL[b];
        end else begin
          stage1[b] <= rawIn[b];
          stage2[b] <= stage1[b];
        end
      end
    end
  endgenerate

  assign syncOut = stage2;

endmodule

// File: rtl/nbf_control.sv
module nbf_control
  import nbf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceS,
  input  logic              oeS,
  input  logic              weS,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cmdData,
  output ctrlStrobes_t      strobes
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-1:0] UNLOCK_A1 = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] UNLOCK_A2 = ADDR_W'(11'h2AA);
  localparam logic [DATA_W-1:0] KEY_1     = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] KEY_2     = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] KEY_ID    = DATA_W'(8'h90);
  localparam logic [DATA_W-1:0] KEY_EXIT  = DATA_W'(8'hF0);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  logic              weQ;
  logic              cmdFire;
  logic              firstOk;
  logic              secondOk;
  logic              thirdOk;
  seqState_t         seq;
  logic              idMode;
  logic [BUSY_W-1:0] busyCnt;
  logic              busy;

  assign cmdFire  = weS & ~weQ & ~ceS & oeS;
  assign firstOk  = (addr == UNLOCK_A1) && (cmdData == KEY_1);
  assign secondOk = (addr == UNLOCK_A2) && (cmdData == KEY_2);
  assign thirdOk  = (addr == UNLOCK_A1) && (cmdData == KEY_ID);
  assign busy     = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ     <= 1'b1;
      seq     <= SEQ_IDLE;
      idMode  <= 1'b0;
      busyCnt <= '0;
    end else begin
      weQ <= weS;
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (cmdFire) begin
        if (cmdData == KEY_EXIT) begin
          seq    <= SEQ_IDLE;
          idMode <= 1'b0;
        end else begin
          unique case (seq)
            SEQ_IDLE: begin
              if (firstOk) seq <= SEQ_GOT1;
              else         idMode <= 1'b0;
            end
            SEQ_GOT1: begin
              if (secondOk) seq <= SEQ_GOT2;
              else begin
                seq    <= SEQ_IDLE;
                idMode <= 1'b0;
              end
            end
            SEQ_GOT2: begin
              seq <= SEQ_IDLE;
              if (thirdOk) begin
                idMode  <= 1'b1;
                busyCnt <= BUSY_LOAD;
              end else begin
                idMode <= 1'b0;
              end
            end
            default: begin
              seq    <= SEQ_IDLE;
              idMode <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    strobes.readEn  = ~ceS & ~oeS & weS;
    strobes.idMode  = idMode;
    strobes.standby = ~rstN | (ceS & ~busy);
  end

  // R4: identification mode is entered only from the last unlock step
  p_id_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> ($past(seq) == SEQ_GOT2) && $past(cmdFire));

  // R6: a wrong first word leaves array-read mode
  p_bad_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFire && seq == SEQ_IDLE && !firstOk) |=> !idMode);

  // R10: the internal operation only starts from an accepted command word
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdFire) && idMode);

endmodule

// File: rtl/nbf_datapath.sv
module nbf_datapath
  import nbf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int ARRAY_WORDS = 16,
  parameter int STABLE_N    = 12,
  parameter logic [7:0] MFR_CODE = 8'h3D,
  parameter logic [7:0] DEV_CODE = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              lowPower
);

  localparam int IDX_W = $clog2(ARRAY_WORDS);
  localparam int CNT_W = $clog2(STABLE_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_N);

  logic [DATA_W-1:0] romWords [ARRAY_WORDS];
  logic [DATA_W-1:0] arrayData;
  logic [DATA_W-1:0] idData;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  stableCnt;

  generate
    for (genvar w = 0; w < ARRAY_WORDS; w++) begin : g_rom
      localparam logic [31:0] WORD_VAL = arrayWord(w);
      assign romWords[w] = WORD_VAL[DATA_W-1:0];
    end
  endgenerate

  assign arrayData = romWords[addr[IDX_W-1:0]];
  assign idData    = {{(DATA_W-8){1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};
  assign dataOut   = strobes.idMode ? idData : arrayData;
  assign dataOutEn = strobes.readEn & ~strobes.standby;

  // address stability timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      stableCnt <= '0;
    end else begin
      addrQ <= addr;
      if (addr != addrQ)          stableCnt <= '0;
      else if (stableCnt < CNT_MAX) stableCnt <= stableCnt + 1'b1;
    end
  end

  assign lowPower = (stableCnt >= CNT_MAX);

  // R8: outputs released whenever standby is flagged
  p_tristate_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.standby |-> !dataOutEn);

  // R11: low power is reached only with a held address
  p_lowpower_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPower) |-> $stable(addrQ));

endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int ARRAY_WORDS = 16,
  parameter int STABLE_N    = 12,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              standby,
  output logic              lowPower
);

  logic [2:0]   syncStrobes;
  ctrlStrobes_t strobes;

  // bit 2 chip enable (resets low so release is immediate), 1 output enable, 0 write enable
  nbf_sync #(.WIDTH(3), .RESET_VAL(3'b011)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({ceN, oeN, weN}),
    .syncOut (syncStrobes)
  );

  nbf_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .ceS     (syncStrobes[2]),
    .oeS     (syncStrobes[1]),
    .weS     (syncStrobes[0]),
    .addr    (addr),
    .cmdData (dataIn),
    .strobes (strobes)
  );

  nbf_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_WORDS(ARRAY_WORDS), .STABLE_N(STABLE_N)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .strobes   (strobes),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn),
    .lowPower  (lowPower)
  );

  assign standby = strobes.standby;

endmodule

// File: tb/nor_bus_front_bench.sv
module nor_bus_front_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOutEn, standby, lowPower;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_bus_front u_nor_bus_front (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .standby(standby), .lowPower(lowPower)
  );

  // ---------------- behavioural reference model ----------------
  int mCe[2], mOe[2], mWe[2];
  int mWePrev = 1, mStep = 0, mId = 0, mBusy = 0, mStable = 0;
  int mAddrPrev = 0;

  function automatic logic [15:0] refWord(input int i);
    return 16'(((i * 32'h1357) ^ 32'hC0DE) & 32'hFFFF);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCe = '{0, 0}; mOe = '{1, 1}; mWe = '{1, 1};
      mWePrev = 1; mStep = 0; mId = 0; mBusy = 0; mStable = 0; mAddrPrev = 0;
    end else begin
      bit fire;
      fire = (mWe[1] == 1) && (mWePrev == 0) && (mCe[1] == 0) && (mOe[1] == 1);
      mWePrev = mWe[1];
      if (mBusy > 0) mBusy--;
      if (fire) begin
        if (dataIn == 16'h00F0) begin mStep = 0; mId = 0; end
        else if (mStep == 0) begin
          if (addr == 11'h555 && dataIn == 16'h00AA) mStep = 1; else mId = 0;
        end else if (mStep == 1) begin
          if (addr == 11'h2AA && dataIn == 16'h0055) mStep = 2;
          else begin mStep = 0; mId = 0; end
        end else begin
          mStep = 0;
          if (addr == 11'h555 && dataIn == 16'h0090) begin mId = 1; mBusy = 8; end
          else mId = 0;
        end
      end
      if (int'(addr) != mAddrPrev) mStable = 0;
      else if (mStable < 12) mStable++;
      mAddrPrev = int'(addr);
      mCe[1] = mCe[0]; mCe[0] = int'(ceN);
      mOe[1] = mOe[0]; mOe[0] = int'(oeN);
      mWe[1] = mWe[0]; mWe[0] = int'(weN);
    end
  end

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, at the falling edge
  always @(negedge clk) begin
    logic eEn, eSb;
    logic [15:0] eData;
    eEn   = rstN && mCe[1] == 0 && mOe[1] == 0 && mWe[1] == 1;
    eSb   = !rstN || (mCe[1] == 1 && mBusy == 0);
    eData = mId ? (addr[0] ? 16'h00A7 : 16'h003D) : refWord(int'(addr[3:0]));
    cmp("R2/R8 model dataOutEn", {15'b0, dataOutEn}, {15'b0, eEn});
    cmp("R8/R10 model standby", {15'b0, standby}, {15'b0, eSb});
    cmp("R11 model lowPower", {15'b0, lowPower}, {15'b0, logic'(mStable >= 12)});
    if (eEn) cmp("R2/R5 model dataOut", dataOut, eData);
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expectRead(input string tag, input logic [15:0] exp);
    @(negedge clk);
    cmp(tag, {15'b0, dataOutEn}, 16'h0001);
    cmp(tag, dataOut, exp);
    tick(1);
  endtask

  task automatic cmdWrite(input logic [10:0] a, input logic [15:0] d);
    oeN = 1; addr = a; dataIn = d;
    tick(3); weN = 0; tick(4); weN = 1; tick(4);
  endtask

  task automatic unlockId();
    cmdWrite(11'h555, 16'h00AA);
    cmdWrite(11'h2AA, 16'h0055);
    cmdWrite(11'h555, 16'h0090);
  endtask

  task automatic readAt(input logic [10:0] a);
    oeN = 0; addr = a; tick(4);
  endtask

  initial begin
    rstN = 1'b0;
    tick(3);
    @(negedge clk);
    // R1: reset state
    cmp("R1 reset standby", {15'b0, standby}, 16'h0001);
    cmp("R1 reset dataOutEn", {15'b0, dataOutEn}, 16'h0000);
    cmp("R1 reset lowPower", {15'b0, lowPower}, 16'h0000);
    tick(1);
    ceN = 0; rstN = 1;
    @(negedge clk);
    cmp("R9 active at release", {15'b0, standby}, 16'h0000);
    tick(1);

    // R2: array reads over several addresses
    readAt(11'h000); expectRead("R2 array word 0", refWord(0));
    readAt(11'h005); expectRead("R2 array word 5", refWord(5));
    readAt(11'h00F); expectRead("R2 array word 15", refWord(15));
    readAt(11'h7A3); expectRead("R2 array word 3 via high addr", refWord(3));

    // R4 and R5: identification entry and codes
    unlockId();
    readAt(11'h000); expectRead("R5 id code low", 16'h003D);
    readAt(11'h001); expectRead("R5 id code high", 16'h00A7);
    readAt(11'h003); expectRead("R4 id mode held", 16'h00A7);

    // R7: exit command at an arbitrary address
    cmdWrite(11'h123, 16'h00F0);
    readAt(11'h001); expectRead("R7 exit to array", refWord(1));

    // R6: second address off by one
    cmdWrite(11'h555, 16'h00AA);
    cmdWrite(11'h2AB, 16'h0055);
    cmdWrite(11'h555, 16'h0090);
    readAt(11'h000); expectRead("R6 bad second word", refWord(0));

    // R6: junk after identification mode
    unlockId();
    readAt(11'h000); expectRead("R4 id entry again", 16'h003D);
    cmdWrite(11'h444, 16'h0012);
    readAt(11'h000); expectRead("R6 junk word exits id", refWord(0));

    // R3: full unlock with output enable low is ignored
    oeN = 0;
    addr = 11'h555; dataIn = 16'h00AA; tick(3); weN = 0; tick(4); weN = 1; tick(4);
    addr = 11'h2AA; dataIn = 16'h0055; tick(3); weN = 0; tick(4); weN = 1; tick(4);
    addr = 11'h555; dataIn = 16'h0090; tick(3); weN = 0; tick(4); weN = 1; tick(4);
    readAt(11'h000); expectRead("R3 write with oe low ignored", refWord(0));

    // R8: deselected with oe low
    ceN = 1; oeN = 0; tick(4);
    @(negedge clk);
    cmp("R8 standby when deselected", {15'b0, standby}, 16'h0001);
    cmp("R8 outputs released", {15'b0, dataOutEn}, 16'h0000);
    tick(1);
    ceN = 0; oeN = 1; tick(3);

    // R10: internal operation keeps the device active
    cmdWrite(11'h555, 16'h00AA);
    cmdWrite(11'h2AA, 16'h0055);
    addr = 11'h555; dataIn = 16'h0090; tick(3); weN = 0; tick(4); weN = 1;
    tick(1); ceN = 1; tick(3);
    @(negedge clk);
    cmp("R10 active while busy", {15'b0, standby}, 16'h0000);
    tick(10);
    @(negedge clk);
    cmp("R10 standby after busy", {15'b0, standby}, 16'h0001);
    tick(1);
    ceN = 0; cmdWrite(11'h000, 16'h00F0);

    // R11: address stability timer
    oeN = 0; addr = 11'h0AB; tick(10);
    @(negedge clk);
    cmp("R11 not yet low power", {15'b0, lowPower}, 16'h0000);
    tick(4);
    @(negedge clk);
    cmp("R11 low power reached", {15'b0, lowPower}, 16'h0001);
    tick(1);
    addr = 11'h0AC; tick(1);
    @(negedge clk);
    cmp("R11 cleared by change", {15'b0, lowPower}, 16'h0000);
    tick(1);

    // R1: reset in identification mode returns to array reads
    unlockId();
    readAt(11'h000); expectRead("R5 id before reset", 16'h003D);
    rstN = 0; tick(2); rstN = 1; tick(1);
    readAt(11'h002); expectRead("R1 array after reset", refWord(2));

    tick(5);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule